// File: doc/BRIEF.md
# Adapter Interrupt Suppression Controller

This block sits in front of an I/O interrupt queue and decides, one request at a time, whether an adapter interrupt request goes on as an I/O interrupt. For each interruption subclass it holds two bits. The first is a "single" bit: only one suppressible interrupt is wanted. The second is a "mute" bit: further suppressible interrupts are withheld.

Software sets the behaviour of a subclass through the mode-change port. It can choose to deliver every interrupt, or to deliver only one suppressible interrupt. In single mode the block mutes the subclass by itself once it has forwarded a suppressible interrupt. After that, suppressible requests are dropped until software writes the mode again. Requests that are not suppressible always pass.

A forwarded request leaves the block as an interrupt word with zero subchannel id, subchannel number and interrupt parameter. Queueing the forwarded interrupt and the indicator memory are outside this block.

Top module: `aisc_ctrl`

## Requirements
- R1: A mode write with code 0 ("all") to a subclass clears both its single bit and its mute bit. From then on every suppressible request for that subclass is forwarded.
- R2: A mode write with code 1 ("single") to a subclass sets its single bit and clears its mute bit. The next suppressible request for that subclass is forwarded.
- R3: A mode write with code 2 or 3 raises `mode_err` for exactly one cycle, in the cycle after the write, and leaves both bits of every subclass unchanged.
- R4: A suppressible request for a subclass whose mute bit is set is dropped: `fwd_vld` stays low in the following cycle.
- R5: A request that is not dropped is forwarded. `fwd_vld` is high in the cycle after the request, with `fwd_word` = (subclass << 27) | (1 << 31). `fwd_sch_id`, `fwd_sch_nr` and `fwd_parm` are zero. `fwd_word` reads zero whenever `fwd_vld` is low.
- R6: Forwarding a suppressible request for a subclass whose single bit is set sets that subclass's mute bit.
- R7: A request that is not suppressible is always forwarded and leaves both bits unchanged.
- R8: Reset clears both bits of every subclass, so every subclass starts in "all" mode.
- R9: A valid mode write and a request that target the same subclass in the same cycle are resolved as follows. The request is judged on the bits held before that cycle. The mode write sets the bits that follow, and it overrides the automatic mute of R6.
- R10: Mode writes and automatic mutes affect only the addressed subclass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_vld | input | 1 | Mode write strobe |
| mode_cls | input | 3 | Subclass addressed by the mode write |
| mode_code | input | 2 | 0 = all, 1 = single, 2 and 3 are invalid |
| inj_vld | input | 1 | Adapter interrupt request strobe |
| inj_cls | input | 3 | Subclass of the request |
| inj_supp | input | 1 | Request is suppressible |
| mode_err | output | 1 | One-cycle pulse: the previous mode write was rejected |
| fwd_vld | output | 1 | One-cycle pulse: an I/O interrupt is forwarded |
| fwd_word | output | 32 | Interrupt word of the forwarded interrupt |
| fwd_sch_id | output | 16 | Subchannel id, always zero |
| fwd_sch_nr | output | 16 | Subchannel number, always zero |
| fwd_parm | output | 32 | Interrupt parameter, always zero |

## Verification
The mode bits cannot be seen directly. A wrong bit therefore shows up only through the next suppressible request for that subclass, one cycle after that request. A stuck mute bit appears as a missing `fwd_vld`, and a mute bit that is never set appears as a second forwarded pulse. To expose such faults, the bench drives pairs of back-to-back suppressible requests after every mode change, after rejected writes and after the same-cycle collision. It also interleaves other subclasses to catch bits that leak between them.

// File: rtl/aisc_pkg.sv
package aisc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned CLS_SHIFT  = 27;
  localparam int unsigned AI_FLAG    = 31;
  localparam int unsigned CODE_W     = 2;

  typedef enum logic [CODE_W-1:0] {
    MODE_ALL    = 2'd0,
    MODE_SINGLE = 2'd1
  } mode_e;

  function automatic logic code_valid(input logic [CODE_W-1:0] code);
    return (code == MODE_ALL) || (code == MODE_SINGLE);
  endfunction

  function automatic logic [WORD_W-1:0] irq_word(input logic [7:0] cls);
    logic [WORD_W-1:0] w;
    w = WORD_W'(cls) << CLS_SHIFT;
    w[AI_FLAG] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/aisc_mode_regs.sv
module aisc_mode_regs
  import aisc_pkg::*;
#(
  parameter int unsigned N_CLS = 8,
  localparam int unsigned CLS_W = $clog2(N_CLS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_vld,
  input  logic [CLS_W-1:0]  mode_cls,
  input  logic [CODE_W-1:0] mode_code,
  input  logic [N_CLS-1:0]  arm_mute,
  output logic [N_CLS-1:0]  single_q,
  output logic [N_CLS-1:0]  mute_q,
  output logic              err_q
);
  logic wr_ok;
  logic wr_bad;
  assign wr_ok  = mode_vld && code_valid(mode_code);
  assign wr_bad = mode_vld && !code_valid(mode_code);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= wr_bad;
  end

  for (genvar i = 0; i < N_CLS; i++) begin : g_cls
    logic hit;
    assign hit = wr_ok && (mode_cls == CLS_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        single_q[i] <= 1'b0;
        mute_q[i]   <= 1'b0;
      end else if (hit) begin
        single_q[i] <= (mode_code == MODE_SINGLE);
        mute_q[i]   <= 1'b0;
      end else if (arm_mute[i]) begin
        mute_q[i]   <= 1'b1;
      end
    end

    // R6: automatic mute lands unless a mode write to this subclass wins
    a_r6_auto_mute: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_mute[i] && !hit) |=> mute_q[i]);
    // R9: a valid write to this subclass always leaves the mute bit clear
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !mute_q[i]);
    // R1: all mode clears the single bit
    a_r1_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode_code == MODE_ALL) |=> !single_q[i]);
  end

  // R3: a rejected write changes nothing when no request can mute
  a_r3_bad_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && arm_mute == '0) |=> ($stable(single_q) && $stable(mute_q) && err_q));
endmodule

// File: rtl/aisc_gate.sv
module aisc_gate
  import aisc_pkg::*;
#(
  parameter int unsigned N_CLS = 8,
  localparam int unsigned CLS_W = $clog2(N_CLS)
)(
  input  logic              inj_vld,
  input  logic [CLS_W-1:0]  inj_cls,
  input  logic              inj_supp,
  input  logic [N_CLS-1:0]  single_q,
  input  logic [N_CLS-1:0]  mute_q,
  output logic              pass,
  output logic              drop,
  output logic [N_CLS-1:0]  arm_mute,
  output logic [WORD_W-1:0] word
);
  logic blocked;
  assign blocked = inj_supp && mute_q[inj_cls];
  assign pass    = inj_vld && !blocked;
  assign drop    = inj_vld && blocked;
  assign word    = irq_word(8'(inj_cls));

  always_comb begin
    arm_mute = '0;
    if (pass && inj_supp && single_q[inj_cls]) arm_mute[inj_cls] = 1'b1;
  end
endmodule

// File: rtl/aisc_ctrl.sv
module aisc_ctrl
  import aisc_pkg::*;
#(
  parameter int unsigned N_CLS = 8,
  localparam int unsigned CLS_W = $clog2(N_CLS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_vld,
  input  logic [CLS_W-1:0]     mode_cls,
  input  logic [CODE_W-1:0]    mode_code,
  input  logic                 inj_vld,
  input  logic [CLS_W-1:0]     inj_cls,
  input  logic                 inj_supp,
  output logic                 mode_err,
  output logic                 fwd_vld,
  output logic [WORD_W-1:0]    fwd_word,
  output logic [15:0]          fwd_sch_id,
  output logic [15:0]          fwd_sch_nr,
  output logic [31:0]          fwd_parm
);
  logic [N_CLS-1:0]  single_q;
  logic [N_CLS-1:0]  mute_q;
  logic [N_CLS-1:0]  arm_mute;
  logic              pass;
  logic              drop;
  logic [WORD_W-1:0] word;

  aisc_mode_regs #(.N_CLS(N_CLS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mode_vld(mode_vld), .mode_cls(mode_cls), .mode_code(mode_code),
    .arm_mute(arm_mute), .single_q(single_q), .mute_q(mute_q),
    .err_q(mode_err)
  );

  aisc_gate #(.N_CLS(N_CLS)) u_gate (
    .inj_vld(inj_vld), .inj_cls(inj_cls), .inj_supp(inj_supp),
    .single_q(single_q), .mute_q(mute_q),
    .pass(pass), .drop(drop), .arm_mute(arm_mute), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_vld  <= 1'b0;
      fwd_word <= '0;
    end else begin
      fwd_vld  <= pass;
      fwd_word <= pass ? word : '0;
    end
  end

  assign fwd_sch_id = '0;
  assign fwd_sch_nr = '0;
  assign fwd_parm   = '0;

  // R4: a muted suppressible request produces no interrupt
  a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !fwd_vld);
  // R7: non-suppressible requests always come out
  a_r7_nonsupp_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && !inj_supp) |=> fwd_vld);
  // R5: forwarded word carries the flag and the subclass
  a_r5_word_form: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> (fwd_word[AI_FLAG] &&
                 fwd_word[CLS_SHIFT +: CLS_W] == $past(inj_cls)));
  // R7: non-suppressible request alone leaves the bits untouched
  a_r7_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && !inj_supp && !mode_vld) |=> ($stable(mute_q) && $stable(single_q)));
endmodule

// File: tb/tb_aisc_ctrl.sv
module tb_aisc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_vld = 1'b0;
  logic [2:0]  mode_cls = '0;
  logic [1:0]  mode_code = '0;
  logic        inj_vld = 1'b0;
  logic [2:0]  inj_cls = '0;
  logic        inj_supp = 1'b0;
  logic        mode_err;
  logic        fwd_vld;
  logic [31:0] fwd_word;
  logic [15:0] fwd_sch_id;
  logic [15:0] fwd_sch_nr;
  logic [31:0] fwd_parm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aisc_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .mode_vld(mode_vld), .mode_cls(mode_cls), .mode_code(mode_code),
    .inj_vld(inj_vld), .inj_cls(inj_cls), .inj_supp(inj_supp),
    .mode_err(mode_err), .fwd_vld(fwd_vld), .fwd_word(fwd_word),
    .fwd_sch_id(fwd_sch_id), .fwd_sch_nr(fwd_sch_nr), .fwd_parm(fwd_parm)
  );

  typedef struct {
    logic        v;
    logic [31:0] w;
    logic        e;
    string       tag;
  } exp_t;

  exp_t sb[$];
  bit m_single [8];
  bit m_mute   [8];

  // driver: one operation per cycle, expectation pushed for the next cycle
  task automatic step(input bit mv, input int mc, input int mcode,
                      input bit iv, input int ic, input bit is, input string tag);
    exp_t x;
    bit fwd;
    @(negedge clk);
    mode_vld = mv; mode_cls = 3'(mc); mode_code = 2'(mcode);
    inj_vld = iv; inj_cls = 3'(ic); inj_supp = is;
    fwd = iv && !(is && m_mute[ic]);
    x.v = fwd;
    x.w = fwd ? (32'h8000_0000 + 32'(ic) * 32'h0800_0000) : 32'h0;
    x.e = mv && (mcode > 1);
    x.tag = tag;
    sb.push_back(x);
    if (fwd && is && m_single[ic]) m_mute[ic] = 1'b1;
    if (mv && mcode <= 1) begin
      m_single[mc] = (mcode == 1);
      m_mute[mc]   = 1'b0;
    end
  endtask

  task automatic inj(input int c, input bit s, input string tag);
    step(1'b0, 0, 0, 1'b1, c, s, tag);
  endtask

  task automatic mode(input int c, input int code, input string tag);
    step(1'b1, c, code, 1'b0, 0, 1'b0, tag);
  endtask

  // monitor: compare one item per cycle, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (fwd_vld !== x.v || fwd_word !== x.w || mode_err !== x.e ||
            fwd_sch_id !== 16'h0 || fwd_sch_nr !== 16'h0 || fwd_parm !== 32'h0) begin
          errors++;
          $display("FAIL %s: got vld=%0b word=%h err=%0b ids=%h/%h/%h exp vld=%0b word=%h err=%0b",
                   x.tag, fwd_vld, fwd_word, mode_err, fwd_sch_id, fwd_sch_nr, fwd_parm,
                   x.v, x.w, x.e);
        end
      end
    end
  end

  initial begin
    #200us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_single[i] = 1'b0; m_mute[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (fwd_vld !== 1'b0 || mode_err !== 1'b0 || fwd_word !== 32'h0) begin
      errors++;
      $display("FAIL R8 reset outputs: got vld=%0b err=%0b word=%h exp 0 0 0",
               fwd_vld, mode_err, fwd_word);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R8: every subclass starts in all mode
    inj(2, 1, "R8 supp after reset");
    inj(2, 1, "R8 supp again");
    inj(0, 1, "R8 subclass 0");
    // R5: word layout at the top subclass
    inj(7, 0, "R5 word subclass 7");
    // R2 and R6: single mode delivers once, then mutes
    mode(2, 1, "R2 set single");
    inj(2, 1, "R2 first supp forwarded");
    inj(3, 1, "R10 other subclass unaffected");
    inj(2, 1, "R4 muted supp dropped");
    inj(2, 0, "R7 nonsupp while muted");
    inj(2, 1, "R7 mute kept after nonsupp");
    // R3: invalid codes rejected, state kept
    mode(2, 2, "R3 code 2 rejected");
    inj(2, 1, "R3 mute survives bad write");
    mode(5, 3, "R3 code 3 rejected");
    inj(5, 1, "R3 all mode kept (1)");
    inj(5, 1, "R3 all mode kept (2)");
    // R1: all mode clears mute and single
    mode(2, 0, "R1 set all");
    inj(2, 1, "R1 supp forwarded (1)");
    inj(2, 1, "R1 supp forwarded (2)");
    // R9: same-cycle write and request
    mode(4, 1, "R9 set single");
    step(1'b1, 4, 1, 1'b1, 4, 1'b1, "R9 collision forwarded");
    inj(4, 1, "R9 write beat auto mute");
    inj(4, 1, "R9 now muted");
    // R9: request judged on old bits, write unmutes afterwards
    step(1'b1, 4, 0, 1'b1, 4, 1'b1, "R9 muted at write cycle");
    inj(4, 1, "R9 after all write");
    // R10: a write to one subclass leaves another muted
    mode(6, 1, "R10 set single 6");
    inj(6, 1, "R10 first on 6");
    mode(1, 0, "R10 write other subclass");
    inj(6, 1, "R10 6 still muted");
    // R3 with request in flight
    step(1'b1, 6, 3, 1'b1, 1, 1'b1, "R3 bad write with request");
    inj(6, 1, "R3 6 still muted");
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, "idle");
    step(1'b0, 0, 0, 1'b0, 0, 1'b0, "idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule